// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block carries one 8-bit companded voice sample in each direction per 8 kHz frame over a strobed serial link. An active-high strobe marks the single 8-bit timeslot, which transmit and receive share. During that slot the block sends the encoder's byte on the serial output, most significant bit first, one bit per rising edge of the bit clock. It also collects eight bits from the serial input on the falling edges and hands the assembled byte to the decoder path.

The bit clock, the strobe and the serial input are sampled in the system clock domain through a short synchronizer, and their edges are detected there. The serial output comes as a data bit plus an output enable, so a pad can tri-state it outside the slot. Either direction can be muted on its own. A muted direction carries the negative-zero quiet code of the selected companding law in place of real data.

The received byte leaves on a valid-only stream. The line cannot be stalled, so there is no ready and no back-pressure. The consumer must take `rx_byte` in the one cycle that `rx_valid` is high, and the byte stays on the port until the next slot delivers a new one. The transmit byte is a plain input that is sampled once per slot.

Top module: `pcm_strobe_port`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first slot, `sdout_oe` is 0, `rx_valid` is 0 and `rx_byte` is 0x00, whatever the strobe does.
- R2: At a strobe rising edge the block drives bit 7 of the transmit byte on `sdout`. Each later bit-clock rising edge inside the slot moves to the next lower bit. A bit-clock rise that coincides with the strobe rise does not shift.
- R3: Within the slot the block samples `sdin` on bit-clock falling edges, MSB first. After the eighth sample it puts the byte on `rx_byte` and raises `rx_valid` for exactly one clock, before the strobe falls (no frame delay).
- R4: `sdout_oe` is 1 only while the strobe is high. It goes to 0 a fixed few cycles after the strobe falls, and `sdout` reads 0 while `sdout_oe` is 0.
- R5: When `tx_mute` is 1 at the strobe rise, the slot transmits the quiet code instead of `tx_byte`.
- R6: When `rx_mute` is 1 at delivery, `rx_byte` takes the quiet code instead of the received bits, and `rx_valid` still pulses once.
- R7: The quiet code is 0x7F when `alaw_sel` is 0 (mu-law) and 0x55 when `alaw_sel` is 1 (A-law).
- R8: After eight bits both directions stop. If the strobe is held longer, `sdout` keeps bit 0 and no second `rx_valid` occurs.
- R9: `tx_byte` is captured at the strobe rise. Changes to it later in the slot do not affect the transmitted bits.
- R10: Bit-clock edges and `sdin` activity while the strobe is low produce no `rx_valid` and leave `sdout_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| strobe | input | 1 | Active-high timeslot strobe, 8 kHz |
| sdin | input | 1 | Serial receive data |
| tx_byte | input | 8 | Parallel byte from the encoder |
| alaw_sel | input | 1 | Companding law: 1 = A-law, 0 = mu-law |
| tx_mute | input | 1 | Replace transmitted byte with quiet code |
| rx_mute | input | 1 | Replace delivered byte with quiet code |
| sdout | output | 1 | Serial transmit data bit |
| sdout_oe | output | 1 | Output enable for the serial data pad |
| rx_byte | output | 8 | Last received byte for the decoder |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_byte` |

## Verification
A wrong bit counter or shift register shows up within the same slot. The serial bits on `sdout` come out reordered, short or repeated, or the valid pulse comes early, late, twice or not at all, and the scoreboard sees the bad byte before the strobe falls. A bad synchronizer or edge detector makes every bit of a slot wrong at once, or lets idle clocking produce an unexpected valid in the gap between slots. Mute and law errors show in the first slot that uses them, as a wrong quiet code in one direction.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  parameter int unsigned SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;

  localparam sample_t QUIET_MU = 8'h7F;
  localparam sample_t QUIET_A  = 8'h55;

  function automatic sample_t quiet_code(input logic alaw);
    return alaw ? QUIET_A : QUIET_MU;
  endfunction
endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic stb_i,
  input  logic din_i,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic stb_level,
  output logic stb_rise,
  output logic din_bit
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [2:0] pipe [SYNC_STAGES];
  logic       bclk_prev, stb_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) pipe[i] <= '0;
      bclk_prev <= 1'b0;
      stb_prev  <= 1'b0;
    end else begin
      pipe[0] <= {bclk_i, stb_i, din_i};
      for (int i = 1; i < int'(SYNC_STAGES); i++) pipe[i] <= pipe[i-1];
      bclk_prev <= pipe[LAST][2];
      stb_prev  <= pipe[LAST][1];
    end
  end

  assign bclk_rise = pipe[LAST][2] & ~bclk_prev;
  assign bclk_fall = ~pipe[LAST][2] & bclk_prev;
  assign stb_level = pipe[LAST][1];
  assign stb_rise  = pipe[LAST][1] & ~stb_prev;
  assign din_bit   = pipe[LAST][0];
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    advance,
  input  sample_t tx_byte,
  input  logic    mute,
  input  logic    alaw,
  output logic    tx_bit
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

  sample_t          sh;
  logic [CNT_W-1:0] cnt;
  logic             can_shift;

  assign can_shift = advance && (cnt < LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= mute ? quiet_code(alaw) : tx_byte;
      cnt <= '0;
    end else if (can_shift) begin
      sh  <= {sh[SAMPLE_W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end
  end

  assign tx_bit = sh[SAMPLE_W-1];

  // R2 / R9: the shift register changes only at a load or an in-slot rise
  a_r9_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(sh));
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_port_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart,
  input  logic    sample,
  input  logic    din_bit,
  input  logic    mute,
  input  logic    alaw,
  output sample_t rx_byte,
  output logic    rx_valid
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_W - 1);

  sample_t          sh;
  logic [CNT_W-1:0] cnt;
  sample_t          assembled;

  assign assembled = {sh[SAMPLE_W-2:0], din_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (restart) begin
        cnt <= '0;
      end else if (sample && cnt < FULL) begin
        sh  <= assembled;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          rx_byte  <= mute ? quiet_code(alaw) : assembled;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R3: the valid strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8: the sample counter never passes a full byte
  a_r8_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R8: once full, no further delivery until a new slot
  a_r8_no_valid_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !restart) |=> !rx_valid);
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                strobe,
  input  logic                sdin,
  input  logic [SAMPLE_W-1:0] tx_byte,
  input  logic                alaw_sel,
  input  logic                tx_mute,
  input  logic                rx_mute,
  output logic                sdout,
  output logic                sdout_oe,
  output logic [SAMPLE_W-1:0] rx_byte,
  output logic                rx_valid
);
  logic bclk_rise, bclk_fall, stb_level, stb_rise, din_bit;
  logic tx_bit, oe_q;

  pcm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_i    (bclk),
    .stb_i     (strobe),
    .din_i     (sdin),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .stb_level (stb_level),
    .stb_rise  (stb_rise),
    .din_bit   (din_bit)
  );

  pcm_tx_shift u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (stb_rise),
    .advance (bclk_rise & stb_level & ~stb_rise),
    .tx_byte (tx_byte),
    .mute    (tx_mute),
    .alaw    (alaw_sel),
    .tx_bit  (tx_bit)
  );

  pcm_rx_shift u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (stb_rise),
    .sample   (bclk_fall & stb_level),
    .din_bit  (din_bit),
    .mute     (rx_mute),
    .alaw     (alaw_sel),
    .rx_byte  (rx_byte),
    .rx_valid (rx_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= stb_level;
  end

  assign sdout_oe = oe_q;
  assign sdout    = oe_q & tx_bit;

  // R4 / R10: a received byte is only delivered inside an open slot
  a_r10_valid_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> sdout_oe);
  // R4: the data pin is quiet whenever the enable is off
  a_r4_data_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdout_oe |-> !sdout);
endmodule

// File: tb/pcm_strobe_port_tb.sv
module pcm_strobe_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0, strobe = 1'b0, sdin = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       alaw_sel = 1'b0, tx_mute = 1'b0, rx_mute = 1'b0;
  logic       sdout, sdout_oe, rx_valid;
  logic [7:0] rx_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  pcm_strobe_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .strobe(strobe), .sdin(sdin),
    .tx_byte(tx_byte), .alaw_sel(alaw_sel), .tx_mute(tx_mute), .rx_mute(rx_mute),
    .sdout(sdout), .sdout_oe(sdout_oe), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] quiet(input logic alaw);
    return alaw ? 8'h55 : 8'h7F;
  endfunction

  // Monitor: pops the scoreboard on every delivered byte
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R8/R10 unexpected rx_valid", rx_byte, 8'h00);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_byte == e, "R3/R6 received byte", rx_byte, e);
      end
    end
  end

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bclk = 1'b1; sdin = ~sdin;
      repeat (6) @(negedge clk);
      chk(sdout_oe == 1'b0, "R10 oe idle", {7'd0, sdout_oe}, 8'h00);
      @(negedge clk); bclk = 1'b0; sdin = ~sdin;
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic run_slot(input logic [7:0] txb, input logic [7:0] rxb, input bit tm,
                          input bit rm, input bit law, input int extra, input bit change_mid,
                          input string tag);
    logic [7:0] exp_tx, got;
    exp_tx = tm ? quiet(law) : txb;
    exp_q.push_back(rm ? quiet(law) : rxb);
    @(negedge clk); tx_mute = tm; rx_mute = rm; alaw_sel = law; tx_byte = txb;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bclk = 1'b1; sdin = rxb[7-i];
      if (i == 0) strobe = 1'b1;
      if (i == 1 && change_mid) tx_byte = ~txb;
      repeat (6) @(negedge clk);
      got[7-i] = sdout;
      if (i == 0) chk(sdout_oe == 1'b1, "R4 oe in slot", {7'd0, sdout_oe}, 8'h01);
      @(negedge clk); bclk = 1'b0;
      repeat (7) @(negedge clk);
    end
    chk(got == exp_tx, tag, got, exp_tx);
    for (int k = 0; k < extra; k++) begin
      @(negedge clk); bclk = 1'b1; sdin = ~sdin;
      repeat (6) @(negedge clk);
      chk(sdout == exp_tx[0], "R8 hold last bit", {7'd0, sdout}, {7'd0, exp_tx[0]});
      @(negedge clk); bclk = 1'b0;
      repeat (7) @(negedge clk);
    end
    @(negedge clk); strobe = 1'b0;
    chk(exp_q.size() == 0, "R3 no frame delay", 8'(exp_q.size()), 8'h00);
    repeat (6) @(negedge clk);
    chk(sdout_oe == 1'b0, "R4 oe off after strobe", {7'd0, sdout_oe}, 8'h00);
    chk(sdout == 1'b0, "R4 data quiet", {7'd0, sdout}, 8'h00);
  endtask

  initial begin
    // R1: reset holds everything inactive even with strobe activity
    repeat (3) @(negedge clk);
    strobe = 1'b1; bclk = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdout_oe == 1'b0, "R1 oe in reset", {7'd0, sdout_oe}, 8'h00);
    strobe = 1'b0; bclk = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdout_oe == 1'b0, "R1 oe after reset", {7'd0, sdout_oe}, 8'h00);
    chk(rx_valid == 1'b0, "R1 valid after reset", {7'd0, rx_valid}, 8'h00);
    chk(rx_byte == 8'h00, "R1 rx_byte after reset", rx_byte, 8'h00);

    idle_bits(3);                                                   // R10
    run_slot(8'hA5, 8'h3C, 0, 0, 0, 0, 0, "R2 tx bits");
    idle_bits(2);
    run_slot(8'h01, 8'h80, 0, 0, 1, 0, 0, "R2 tx single low bit");
    run_slot(8'h9A, 8'hFF, 1, 0, 0, 0, 0, "R5/R7 tx mute mu-law");
    run_slot(8'h9A, 8'h00, 1, 0, 1, 0, 0, "R5/R7 tx mute A-law");
    run_slot(8'h96, 8'hC7, 0, 1, 1, 0, 0, "R6 tx while rx muted A");
    run_slot(8'h42, 8'h18, 0, 1, 0, 0, 0, "R6 tx while rx muted mu");
    idle_bits(2);
    run_slot(8'hC3, 8'h5A, 0, 0, 0, 0, 1, "R9 mid-slot change");
    run_slot(8'h6E, 8'h81, 0, 0, 0, 3, 0, "R8 long strobe bit0=0");
    run_slot(8'h81, 8'h7E, 0, 0, 1, 2, 0, "R8 long strobe bit0=1");
    idle_bits(3);
    chk(rx_byte == 8'h7E, "R10 rx_byte unchanged by idle", rx_byte, 8'h7E);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule